// File: doc/BRIEF.md
# Receive Buffer Pause Flow Controller

This block watches how full a receive buffer is and asks a MAC to send pause frames. When the fill level rises above a programmable upper mark, it requests a "stop" pause frame that carries the pre-programmed pause time. Later, once the fill level drops below a lower mark, it requests a "resume" frame that carries a pause time of zero. Both marks are counted in 64-byte units. The gap between them provides hysteresis, so the link does not toggle on every byte that moves through the buffer.

The two marks are held in one 21-bit threshold word. It is loaded through a write strobe and resets to 0x00078. A four-state controller runs the exchange with the MAC. A request stays raised until the MAC acknowledges it. The resume frame can only follow a stop frame that has been acknowledged. A caller turns the resume frame off by setting the lower mark equal to the buffer size, also given in 64-byte units. When the enable is dropped, the controller returns to idle at once.

Top module: `rx_pause_ctrl`

## Requirements
- R1: After a synchronous reset, `fsm_state` is 0 (idle) and `pause_req` and `pause_xon` are 0. The threshold word holds 0x00078, which gives a stop mark of 120 units (7680 bytes) and a resume mark of 0.
- R2: In idle with `enable` high, an occupancy strictly greater than stop_mark*64 moves the controller to state 1 at the next clock edge, with `pause_req`=1 and `pause_xon`=0 (programmed pause time). An occupancy equal to stop_mark*64 does nothing.
- R3: In state 1 or state 3, `pause_req` stays at 1 and the state does not change on every clock where `mac_ack` is low.
- R4: In state 1, `mac_ack` moves the controller to state 2 (waiting to resume) at the next edge, and `pause_req` drops to 0.
- R5: In state 2, when the resume mark differs from `fifo_units`, an occupancy strictly below resume_mark*64 moves the controller to state 3 with `pause_req`=1 and `pause_xon`=1 (zero pause time). An occupancy equal to resume_mark*64 keeps it in state 2. State 3 is only reached from state 2.
- R6: In state 3, `mac_ack` returns the controller to idle. Conditions are evaluated again from idle, so an occupancy still above the stop mark raises a new stop request one cycle later.
- R7: When resume_mark equals `fifo_units`, no resume request is ever made. In state 2 the controller returns to idle without a request once occupancy is at or below stop_mark*64.
- R8: With `enable` low, the controller enters idle at the next edge from any state and `pause_req` is 0. No resume request is made.
- R9: `cfg_we` loads `cfg_wdata` into the threshold word, and the new marks take effect from the next cycle. The stop mark is bits 8:0 and the resume mark is bits 20:12. Bits 11:9 have no effect.
- R10: `mac_ack` has no effect in idle or in state 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Flow control enable |
| occupancy | input | OCC_W | Receive buffer fill level in bytes |
| fifo_units | input | 9 | Buffer size in 64-byte units |
| cfg_we | input | 1 | Threshold word write strobe |
| cfg_wdata | input | 21 | Threshold word: stop mark in 8:0, resume mark in 20:12 |
| mac_ack | input | 1 | MAC has accepted the pending pause request |
| pause_req | output | 1 | Pause frame request |
| pause_xon | output | 1 | 0: use programmed pause time, 1: pause time zero |
| fsm_state | output | 2 | Controller state: 0 idle, 1 wait stop ack, 2 wait resume, 3 wait resume ack |

## Verification
The hardest situation to reach is the resume path while the resume frame is switched off: the controller must already be in state 2 when the lower mark equals the buffer size. The stimulus reaches it by reprogramming the threshold word and the buffer size, then pushing occupancy over the stop mark and acknowledging. After that it walks occupancy down across the stop mark in single-byte steps. A second hard case is an acknowledge that arrives while occupancy is still high. The bench holds occupancy above the stop mark during the resume acknowledge and checks that a new stop request is raised on the next cycle.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int TH_W     = 9;
  localparam int QUANT_SH = 6;
  localparam int CFG_W    = 21;
  localparam int STOP_LSB = 0;
  localparam int RES_LSB  = 12;
  localparam logic [CFG_W-1:0] CFG_RST = 21'h00078;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_STOP_ACK = 2'd1,
    ST_RES_WAIT = 2'd2,
    ST_RES_ACK  = 2'd3
  } fc_state_e;
endpackage

// File: rtl/fc_thresh_reg.sv
module fc_thresh_reg
  import fc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [TH_W-1:0]  stop_mark,
  output logic [TH_W-1:0]  res_mark
);
  logic unused_gap;
  assign unused_gap = ^wdata[RES_LSB-1:STOP_LSB+TH_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_mark <= CFG_RST[STOP_LSB +: TH_W];
      res_mark  <= CFG_RST[RES_LSB +: TH_W];
    end else if (we) begin
      stop_mark <= wdata[STOP_LSB +: TH_W];
      res_mark  <= wdata[RES_LSB +: TH_W];
    end
  end
endmodule

// File: rtl/fc_cross_detect.sv
module fc_cross_detect
  import fc_pkg::*;
#(
  parameter int OCC_W = 16
) (
  input  logic [OCC_W-1:0] occupancy,
  input  logic [TH_W-1:0]  stop_mark,
  input  logic [TH_W-1:0]  res_mark,
  input  logic [TH_W-1:0]  fifo_units,
  output logic             over_stop,
  output logic             under_res,
  output logic             res_off
);
  localparam int MARK_W = TH_W + QUANT_SH;
  localparam int CMP_W  = ((OCC_W > MARK_W) ? OCC_W : MARK_W) + 1;

  logic [CMP_W-1:0] occ_x, stop_x, res_x;

  always_comb begin
    occ_x  = CMP_W'(occupancy);
    stop_x = CMP_W'({stop_mark, {QUANT_SH{1'b0}}});
    res_x  = CMP_W'({res_mark, {QUANT_SH{1'b0}}});
    over_stop = occ_x > stop_x;
    under_res = occ_x < res_x;
    res_off   = (res_mark == fifo_units);
  end
endmodule

// File: rtl/fc_pause_fsm.sv
module fc_pause_fsm
  import fc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       ack,
  input  logic       over_stop,
  input  logic       under_res,
  input  logic       res_off,
  output logic [1:0] state,
  output logic       req,
  output logic       xon
);
  fc_state_e cur, nxt;

  always_comb begin
    nxt = cur;
    if (!enable) begin
      nxt = ST_IDLE;
    end else begin
      unique case (cur)
        ST_IDLE:     if (over_stop) nxt = ST_STOP_ACK;
        ST_STOP_ACK: if (ack) nxt = ST_RES_WAIT;
        ST_RES_WAIT: begin
          if (res_off) begin
            if (!over_stop) nxt = ST_IDLE;
          end else if (under_res) begin
            nxt = ST_RES_ACK;
          end
        end
        ST_RES_ACK:  if (ack) nxt = ST_IDLE;
        default:     nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= ST_IDLE;
      req <= 1'b0;
      xon <= 1'b0;
    end else begin
      cur <= nxt;
      req <= (nxt == ST_STOP_ACK) || (nxt == ST_RES_ACK);
      xon <= (nxt == ST_RES_ACK);
    end
  end

  assign state = cur;
endmodule

// File: rtl/rx_pause_ctrl.sv
module rx_pause_ctrl
  import fc_pkg::*;
#(
  parameter int OCC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [OCC_W-1:0] occupancy,
  input  logic [8:0]       fifo_units,
  input  logic             cfg_we,
  input  logic [20:0]      cfg_wdata,
  input  logic             mac_ack,
  output logic             pause_req,
  output logic             pause_xon,
  output logic [1:0]       fsm_state
);
  logic [TH_W-1:0] stop_mark, res_mark;
  logic            over_stop, under_res, res_off;

  fc_thresh_reg u_thr (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .stop_mark(stop_mark), .res_mark(res_mark)
  );

  fc_cross_detect #(.OCC_W(OCC_W)) u_cmp (
    .occupancy(occupancy), .stop_mark(stop_mark), .res_mark(res_mark),
    .fifo_units(fifo_units), .over_stop(over_stop),
    .under_res(under_res), .res_off(res_off)
  );

  fc_pause_fsm u_fsm (
    .clk(clk), .rst(rst), .enable(enable), .ack(mac_ack),
    .over_stop(over_stop), .under_res(under_res), .res_off(res_off),
    .state(fsm_state), .req(pause_req), .xon(pause_xon)
  );
endmodule

// File: rtl/rx_pause_ctrl_chk.sv
module rx_pause_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       enable,
  input logic       mac_ack,
  input logic [1:0] fsm_state,
  input logic       pause_req,
  input logic       pause_xon
);
  p_hold_req_r3: assert property (@(posedge clk) disable iff (rst)
    (enable && !mac_ack && (fsm_state == 2'd1 || fsm_state == 2'd3))
      |=> ($stable(fsm_state) && pause_req));

  p_stop_ack_r4: assert property (@(posedge clk) disable iff (rst)
    (enable && mac_ack && fsm_state == 2'd1) |=> (fsm_state == 2'd2 && !pause_req));

  p_res_from_wait_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(fsm_state == 2'd3) |-> ($past(fsm_state) == 2'd2));

  p_zero_time_r5: assert property (@(posedge clk) disable iff (rst)
    pause_xon |-> (fsm_state == 2'd3 && pause_req));

  p_res_ack_r6: assert property (@(posedge clk) disable iff (rst)
    (enable && mac_ack && fsm_state == 2'd3) |=> (fsm_state == 2'd0));

  p_disable_r8: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (fsm_state == 2'd0 && !pause_req));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (fsm_state == 2'd0 || fsm_state == 2'd2) |-> !pause_req);
endmodule

bind rx_pause_ctrl rx_pause_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .enable(enable), .mac_ack(mac_ack),
  .fsm_state(fsm_state), .pause_req(pause_req), .pause_xon(pause_xon)
);

// File: tb/test_rx_pause_ctrl.sv
module test_rx_pause_ctrl;
  localparam int CLK_P = 10;
  localparam int OCC_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             enable = 1'b0;
  logic [OCC_W-1:0] occupancy = '0;
  logic [8:0]       fifo_units = 9'd200;
  logic             cfg_we = 1'b0;
  logic [20:0]      cfg_wdata = '0;
  logic             mac_ack = 1'b0;
  logic             pause_req, pause_xon;
  logic [1:0]       fsm_state;

  int total = 0;
  int bad = 0;
  string phase = "R1";

  int m_st = 0;
  int m_stop = 120;
  int m_res = 0;

  always #(CLK_P/2) clk = ~clk;

  rx_pause_ctrl #(.OCC_W(OCC_W)) i_rx_pause_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .occupancy(occupancy),
    .fifo_units(fifo_units), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .mac_ack(mac_ack), .pause_req(pause_req), .pause_xon(pause_xon),
    .fsm_state(fsm_state)
  );

  // behavioural reference
  always @(posedge clk) begin
    int n;
    if (rst) begin
      m_st = 0; m_stop = 120; m_res = 0;
    end else begin
      n = m_st;
      if (!enable) n = 0;
      else case (m_st)
        0: if (int'(occupancy) > m_stop * 64) n = 1;
        1: if (mac_ack) n = 2;
        2: begin
          if (m_res == int'(fifo_units)) begin
            if (int'(occupancy) <= m_stop * 64) n = 0;
          end else if (int'(occupancy) < m_res * 64) n = 3;
        end
        default: if (mac_ack) n = 0;
      endcase
      if (cfg_we) begin
        m_stop = int'(cfg_wdata[8:0]);
        m_res  = int'(cfg_wdata[20:12]);
      end
      m_st = n;
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk(int'(fsm_state), m_st, {phase, " model state"});
      chk(int'(pause_req), int'(m_st == 1 || m_st == 3), {phase, " model req"});
      chk(int'(pause_xon), int'(m_st == 3), {phase, " model xon"});
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input int st, input int rq, input int xn, input string tag);
    chk(int'(fsm_state), st, {tag, " state"});
    chk(int'(pause_req), rq, {tag, " req"});
    chk(int'(pause_xon), xn, {tag, " xon"});
  endtask

  initial begin
    #(CLK_P * 20000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    phase = "R1";
    expect_out(0, 0, 0, "R1 reset");
    enable = 1'b1;
    occupancy = 16'd7680;           // equal to default stop mark: no request
    step(2);
    expect_out(0, 0, 0, "R1 default stop mark boundary");

    phase = "R2";
    occupancy = 16'd7681;
    step(1);
    expect_out(1, 1, 0, "R2 stop request");

    phase = "R3";
    step(3);
    expect_out(1, 1, 0, "R3 held without ack");

    phase = "R4";
    mac_ack = 1'b1;
    step(1);
    mac_ack = 1'b0;
    expect_out(2, 0, 0, "R4 stop acked");

    phase = "R10";
    mac_ack = 1'b1;
    step(2);
    mac_ack = 1'b0;
    expect_out(2, 0, 0, "R10 ack in wait state ignored");

    phase = "R9";
    // stop=10 (640 B), resume=4 (256 B), junk in bits 11:9
    cfg_wdata = (21'd4 << 12) | (21'h7 << 9) | 21'd10;
    cfg_we = 1'b1;
    step(1);
    cfg_we = 1'b0;
    occupancy = 16'd256;
    step(2);
    expect_out(2, 0, 0, "R9 new resume mark boundary");

    phase = "R5";
    occupancy = 16'd255;
    step(1);
    expect_out(3, 1, 1, "R5 resume request");
    step(2);
    expect_out(3, 1, 1, "R3 resume held");

    phase = "R6";
    occupancy = 16'd700;
    mac_ack = 1'b1;
    step(1);
    mac_ack = 1'b0;
    expect_out(0, 0, 0, "R6 resume acked");
    step(1);
    expect_out(1, 1, 0, "R6 re-evaluated stop");

    phase = "R8";
    enable = 1'b0;
    step(1);
    expect_out(0, 0, 0, "R8 disabled");
    occupancy = 16'd0;
    step(2);
    expect_out(0, 0, 0, "R8 no resume after disable");
    enable = 1'b1;

    phase = "R9";
    occupancy = 16'd640;
    step(2);
    expect_out(0, 0, 0, "R9 stop mark 10 boundary");

    phase = "R7";
    fifo_units = 9'd4;
    occupancy = 16'd641;
    step(1);
    expect_out(1, 1, 0, "R7 stop with resume off");
    mac_ack = 1'b1;
    step(1);
    mac_ack = 1'b0;
    expect_out(2, 0, 0, "R7 wait");
    step(2);
    expect_out(2, 0, 0, "R7 still above stop mark");
    occupancy = 16'd640;
    step(1);
    expect_out(0, 0, 0, "R7 silent return to idle");
    occupancy = 16'd0;
    step(3);
    expect_out(0, 0, 0, "R7 no resume frame");

    phase = "R10";
    mac_ack = 1'b1;
    step(2);
    mac_ack = 1'b0;
    expect_out(0, 0, 0, "R10 ack in idle ignored");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule